// File: doc/BRIEF.md
# Reference-Timed Frequency Meter

This block measures the frequency of one of several test clocks against a reference clock whose rate software knows. Software writes the reference rate in kHz, a window code `k` and optional lower and upper kHz bounds. It then writes a source number. That write starts a measurement. The block opens a window of 2^k reference cycles and counts the rising edges of the chosen test clock inside it. It then turns the count into kHz with a fractional part and grades the value against the bounds.

Edges are counted in the test clock's own domain. The count is moved into the reference domain with a toggle request and acknowledge pair. Each toggle makes the test side capture its running count and restart it. The window is a power of two, so scaling needs only a multiply and a shift.

Source 0 selects no clock. A measurement on source 0 still times its full window and then reports zero. Software reads a status word to follow progress. It must wait for the busy flag to fall before starting another measurement.

Top module: `refclk_freq_meter`

## Requirements
- R1: After reset, the following registers read 0: status, result, reference kHz, lower bound, window code and source. The upper bound reads 0xFFFFFFFF.
- R2: A write to the source register (address 4) while idle starts a measurement. On the next cycle, status bit 0 (busy) reads 1 and status bit 1 (valid) reads 0.
- R3: Busy stays high for at least 2^k reference cycles, where k is the window code (address 3). After that, valid rises and busy falls within a short handshake delay.
- R4: The result register (address 6) holds the measured rate as unsigned fixed point: integer kHz in bits [31:5] and a 5-bit fraction in bits [4:0]. Its value is floor(n·refkHz·32 / 2^k), where n is the number of test edges in the window, accurate to ±1 edge.
- R5: Source 0 means no clock. The measurement still completes, and the result is 0.
- R6: With valid set, exactly one grade bit is set. Bit 3 (slow) means the integer kHz is below the lower bound (address 1). Bit 4 (fast) means it is above the upper bound (address 2). Bit 2 (pass) means neither. While busy, all grade bits are 0.
- R7: With a lower bound of 0 and an upper bound of 0xFFFFFFFF, every result grades as pass.
- R8: A write to the source register while busy is ignored. The source readback does not change, and the measurement finishes on the original source.
- R9: Result and status keep their values between measurements, even when configuration registers are written.
- R10: A scaled value that does not fit in 32 bits saturates to 0xFFFFFFFF.
- R11: The reference kHz (address 0), bounds, window code and source read back the values last accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all registers and the window timer run on it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| tclk_i | input | NUM_SRC | Test clocks; source s selects bit s-1 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
The assertions assume that the selected test clock keeps running while a measurement is in progress. If it stops, the acknowledge toggle never returns and the sample step cannot finish. They also assume that source writes during a measurement arrive only as the deliberate ignored case. The stimulus keeps every test clock free-running and offsets its phase from the reference clock. It always waits for busy to fall before the next start, except in the one test that writes the source mid-window. Result checks allow one edge of uncertainty at each end of the window.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_REFKHZ = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_LO     = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_HI     = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_IVL    = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_SRC    = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_RESULT = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_SAMPLE
    } fsm_e;

endpackage

// File: rtl/fcm_clk_sel.sv
module fcm_clk_sel #(
    parameter int NUM_SRC = 3,
    parameter int SRC_W   = 2
) (
    input  logic [SRC_W-1:0]   sel_i,
    input  logic [NUM_SRC-1:0] tclk_i,
    output logic               tclk_o
);
    // source 0 (and any unmatched code) yields a quiet low clock
    always_comb begin
        tclk_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_i == SRC_W'(i + 1)) tclk_o = tclk_i[i];
        end
    end
endmodule

// File: rtl/fcm_edge_cnt.sv
module fcm_edge_cnt #(
    parameter int CNT_W = 20
) (
    input  logic             tclk_i,
    input  logic             rst_n,
    input  logic             req_tgl_i,
    output logic             ack_tgl_o,
    output logic [CNT_W-1:0] snap_o
);
    typedef struct packed {
        logic             req_s1;
        logic             req_s2;
        logic             seen;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
    } tst_t;

    tst_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.req_s1 = req_tgl_i;
        st_d.req_s2 = st_q.req_s1;
        if (st_q.req_s2 != st_q.seen) begin
            // capture and restart; this edge opens the next interval
            st_d.seen = st_q.req_s2;
            st_d.snap = st_q.cnt;
            st_d.cnt  = CNT_W'(1);
        end else if (st_q.cnt != '1) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge tclk_i or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tgl_o = st_q.seen;
    assign snap_o    = st_q.snap;
endmodule

// File: rtl/fcm_scale.sv
module fcm_scale #(
    parameter int CNT_W  = 20,
    parameter int KHZ_W  = 32,
    parameter int FRAC_W = 5,
    parameter int IVL_W  = 4
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [KHZ_W-1:0] ref_khz_i,
    input  logic [IVL_W-1:0] ivl_i,
    input  logic [KHZ_W-1:0] lo_i,
    input  logic [KHZ_W-1:0] hi_i,
    output logic [KHZ_W-1:0] result_o,
    output logic             pass_o,
    output logic             slow_o,
    output logic             fast_o
);
    localparam int PROD_W = CNT_W + KHZ_W + FRAC_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;
    logic [KHZ_W-1:0]  int_khz;

    always_comb begin
        prod    = (PROD_W'(count_i) * PROD_W'(ref_khz_i)) << FRAC_W;
        shifted = prod >> ivl_i;
        if (|shifted[PROD_W-1:KHZ_W]) result_o = '1;
        else                          result_o = shifted[KHZ_W-1:0];
        int_khz = KHZ_W'(result_o >> FRAC_W);
        slow_o  = (int_khz < lo_i);
        fast_o  = !slow_o && (int_khz > hi_i);
        pass_o  = !slow_o && !fast_o;
    end
endmodule

// File: rtl/refclk_freq_meter.sv
module refclk_freq_meter
    import fcm_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int CNT_W   = 20,
    parameter int KHZ_W   = 32,
    parameter int FRAC_W  = 5,
    parameter int IVL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tclk_i,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [KHZ_W-1:0]   wdata,
    output logic [KHZ_W-1:0]   rdata
);
    localparam int SRC_W = $clog2(NUM_SRC + 1);
    localparam int TMR_W = 2 ** IVL_W;

    typedef struct packed {
        logic [KHZ_W-1:0] ref_khz;
        logic [KHZ_W-1:0] lim_lo;
        logic [KHZ_W-1:0] lim_hi;
        logic [IVL_W-1:0] ivl;
        logic [SRC_W-1:0] sel;
        fsm_e             fsm;
        logic [TMR_W-1:0] timer;
        logic             req;
        logic             ack_s1;
        logic             ack_s2;
        logic             valid;
        logic             pass;
        logic             slow;
        logic             fast;
        logic [KHZ_W-1:0] result;
    } regs_t;

    regs_t st_q, st_d;

    logic             tclk_sel;
    logic             ack_tgl;
    logic [CNT_W-1:0] snap;
    logic [CNT_W-1:0] cnt_in;
    logic [KHZ_W-1:0] sc_result;
    logic             sc_pass, sc_slow, sc_fast;
    logic             busy;
    logic             null_src;
    logic             hs_idle;

    fcm_clk_sel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_sel (
        .sel_i  (st_q.sel),
        .tclk_i (tclk_i),
        .tclk_o (tclk_sel)
    );

    fcm_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
        .tclk_i    (tclk_sel),
        .rst_n     (rst_n),
        .req_tgl_i (st_q.req),
        .ack_tgl_o (ack_tgl),
        .snap_o    (snap)
    );

    assign null_src = (st_q.sel == '0);
    assign cnt_in   = null_src ? '0 : snap;
    assign busy     = (st_q.fsm != ST_IDLE);
    assign hs_idle  = (st_q.ack_s2 == st_q.req);

    fcm_scale #(.CNT_W(CNT_W), .KHZ_W(KHZ_W), .FRAC_W(FRAC_W), .IVL_W(IVL_W)) u_scale (
        .count_i   (cnt_in),
        .ref_khz_i (st_q.ref_khz),
        .ivl_i     (st_q.ivl),
        .lo_i      (st_q.lim_lo),
        .hi_i      (st_q.lim_hi),
        .result_o  (sc_result),
        .pass_o    (sc_pass),
        .slow_o    (sc_slow),
        .fast_o    (sc_fast)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ack_s1 = ack_tgl;
        st_d.ack_s2 = st_q.ack_s1;

        if (wr_en) begin
            case (addr)
                ADR_REFKHZ: st_d.ref_khz = wdata;
                ADR_LO:     st_d.lim_lo  = wdata;
                ADR_HI:     st_d.lim_hi  = wdata;
                ADR_IVL:    st_d.ivl     = wdata[IVL_W-1:0];
                ADR_SRC: begin
                    if (!busy) begin
                        st_d.sel   = wdata[SRC_W-1:0];
                        st_d.fsm   = ST_WINDOW;
                        st_d.timer = (TMR_W'(1) << st_q.ivl) - TMR_W'(1);
                        st_d.valid = 1'b0;
                        st_d.pass  = 1'b0;
                        st_d.slow  = 1'b0;
                        st_d.fast  = 1'b0;
                        // opening toggle clears the test-side count
                        if (wdata[SRC_W-1:0] != '0) st_d.req = ~st_q.req;
                    end
                end
                default: ;
            endcase
        end

        case (st_q.fsm)
            ST_WINDOW: begin
                if (st_q.timer != '0) begin
                    st_d.timer = st_q.timer - 1'b1;
                end else if (null_src) begin
                    st_d.fsm    = ST_IDLE;
                    st_d.valid  = 1'b1;
                    st_d.result = sc_result;
                    st_d.pass   = sc_pass;
                    st_d.slow   = sc_slow;
                    st_d.fast   = sc_fast;
                end else if (hs_idle) begin
                    st_d.req = ~st_q.req;
                    st_d.fsm = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (hs_idle) begin
                    st_d.fsm    = ST_IDLE;
                    st_d.valid  = 1'b1;
                    st_d.result = sc_result;
                    st_d.pass   = sc_pass;
                    st_d.slow   = sc_slow;
                    st_d.fast   = sc_fast;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.lim_hi <= '1;
            st_q.fsm    <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (addr)
            ADR_REFKHZ: rdata = st_q.ref_khz;
            ADR_LO:     rdata = st_q.lim_lo;
            ADR_HI:     rdata = st_q.lim_hi;
            ADR_IVL:    rdata = KHZ_W'(st_q.ivl);
            ADR_SRC:    rdata = KHZ_W'(st_q.sel);
            ADR_STATUS: rdata = KHZ_W'({st_q.fast, st_q.slow, st_q.pass, st_q.valid, busy});
            ADR_RESULT: rdata = st_q.result;
            default:    rdata = '0;
        endcase
    end

    // R2: an idle source write starts a measurement
    a_r2_start_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_SRC && !busy) |=> busy);

    // R3: busy and valid never overlap
    a_r3_busy_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && st_q.valid));

    // R6: exactly one grade once valid
    a_r6_one_grade: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> $onehot({st_q.pass, st_q.slow, st_q.fast}));

    // R6: no grade while measuring
    a_r6_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(st_q.pass || st_q.slow || st_q.fast));

    // R8: source held during a measurement
    a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && addr == ADR_SRC) |=> $stable(st_q.sel));

    // R9: result only moves at the end of a measurement
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (busy || $stable(st_q.result)));

    // R5: null source reports zero
    a_r5_null_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && null_src) |-> (st_q.result == '0));

endmodule

// File: tb/refclk_freq_meter_tb.sv
`timescale 1ns/1ps
module refclk_freq_meter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tclk0 = 1'b0, tclk1 = 1'b0, tclk2 = 1'b0;
    logic [2:0]  tclk;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    assign tclk = {tclk2, tclk1, tclk0};

    refclk_freq_meter u_dut (
        .clk(clk), .rst_n(rst_n), .tclk_i(tclk),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;
    initial begin #3;   forever #10 tclk0 = ~tclk0; end   // 20 ns
    initial begin #7;   forever #20 tclk1 = ~tclk1; end   // 40 ns
    initial begin #1.5; forever #3  tclk2 = ~tclk2; end   // 6 ns

    typedef struct {
        longint lo;
        longint hi;
        logic [2:0] flags;
        int win;
        string rtag;
        string ftag;
    } exp_t;

    typedef struct {
        longint res;
        logic [31:0] st;
        int nb;
    } act_t;

    exp_t exp_q[$];
    act_t act_q[$];

    localparam logic [2:0] F_PASS = 3'b001, F_SLOW = 3'b010, F_FAST = 3'b100;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic longint scaled(longint n, longint rk, int ivl);
        longint v;
        v = ((n * rk) << 5) >> ivl;
        if (v > 64'sh0_FFFF_FFFF) v = 64'sh0_FFFF_FFFF;
        return v;
    endfunction

    task automatic run_meas(input int src, input int per_ps, input int ivl, input longint rk,
                            input longint lo, input longint hi, input logic [2:0] fl,
                            input string rtag, input string ftag, input bit poke);
        exp_t e;
        act_t a;
        logic [31:0] v;
        longint w, nlo, nhi;
        w = longint'(1) << ivl;
        if (per_ps == 0) begin
            nlo = 0; nhi = 0;
        end else begin
            nlo = (w * 10000) / per_ps - 1;
            if (nlo < 0) nlo = 0;
            nhi = (w * 10000 + per_ps - 1) / per_ps + 1;
        end
        e.lo = scaled(nlo, rk, ivl);
        e.hi = scaled(nhi, rk, ivl);
        e.flags = fl; e.win = int'(w); e.rtag = rtag; e.ftag = ftag;
        bus_wr(3'd0, rk[31:0]);
        bus_wr(3'd1, lo[31:0]);
        bus_wr(3'd2, hi[31:0]);
        bus_wr(3'd3, 32'(ivl));
        exp_q.push_back(e);
        bus_wr(3'd4, 32'(src));
        bus_rd(3'd5, v);
        chk(v[0] == 1'b1 && v[1] == 1'b0, "R2 busy set valid clear", longint'(v[1:0]), 1);
        a.nb = 1;
        if (poke) begin
            bus_wr(3'd4, 32'd3);
            a.nb += 2;
            bus_rd(3'd4, v);
            chk(v == 32'(src), "R8 source write ignored while busy", v, src);
        end
        forever begin
            @(negedge clk);
            bus_rd(3'd5, v);
            if (!v[0]) break;
            a.nb++;
        end
        a.st = v;
        bus_rd(3'd6, v);
        a.res = longint'(v);
        act_q.push_back(a);
    endtask

    // monitor: pairs each finished measurement with its expectation
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                act_t a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                chk(a.res >= e.lo && a.res <= e.hi, {e.rtag, " result in range"}, a.res, e.lo);
                chk(a.st[4:2] == e.flags, {e.ftag, " grade bits"}, longint'(a.st[4:2]), longint'(e.flags));
                chk(a.st[1] == 1'b1, "R3 valid after window", longint'(a.st[1]), 1);
                chk(a.nb >= e.win && a.nb <= e.win + 30, "R3 busy length", a.nb, e.win);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, res_keep, st_keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(3'd5, v); chk(v == 0, "R1 status", v, 0);
        bus_rd(3'd6, v); chk(v == 0, "R1 result", v, 0);
        bus_rd(3'd0, v); chk(v == 0, "R1 refkhz", v, 0);
        bus_rd(3'd1, v); chk(v == 0, "R1 lower bound", v, 0);
        bus_rd(3'd2, v); chk(v == 32'hFFFF_FFFF, "R1 upper bound", v, 32'hFFFF_FFFF);
        bus_rd(3'd3, v); chk(v == 0, "R1 window code", v, 0);
        bus_rd(3'd4, v); chk(v == 0, "R1 source", v, 0);

        // 50 MHz, default bounds: R4 / R7
        run_meas(1, 20000, 6, 100000, 0, 32'hFFFF_FFFF, F_PASS, "R4", "R7", 0);

        // R11 readbacks
        bus_rd(3'd3, v); chk(v == 6, "R11 window code", v, 6);
        bus_rd(3'd0, v); chk(v == 100000, "R11 refkhz", v, 100000);
        bus_rd(3'd4, v); chk(v == 1, "R11 source", v, 1);
        bus_rd(3'd1, v); chk(v == 0, "R11 lower bound", v, 0);

        // R9 hold across idle time and config writes
        bus_rd(3'd6, res_keep);
        bus_rd(3'd5, st_keep);
        repeat (40) @(negedge clk);
        bus_wr(3'd0, 32'd1);
        bus_wr(3'd1, 32'd77);
        bus_rd(3'd6, v); chk(v == res_keep, "R9 result held", v, res_keep);
        bus_rd(3'd5, v); chk(v == st_keep, "R9 status held", v, st_keep);

        // 25 MHz below lower bound: R6 slow
        run_meas(2, 40000, 8, 100000, 30000, 32'hFFFF_FFFF, F_SLOW, "R4", "R6 slow", 0);
        // ~166 MHz above upper bound: R6 fast
        run_meas(3, 6000, 7, 100000, 0, 100000, F_FAST, "R4", "R6 fast", 0);
        // null source, lower bound 10: R5 and slow
        run_meas(0, 0, 5, 100000, 10, 32'hFFFF_FFFF, F_SLOW, "R5", "R6 null slow", 0);
        // null source, open bounds: R5 and pass
        run_meas(0, 0, 4, 100000, 0, 32'hFFFF_FFFF, F_PASS, "R5", "R7 null pass", 0);
        // source write while busy ignored: R8
        run_meas(1, 20000, 8, 100000, 0, 32'hFFFF_FFFF, F_PASS, "R8", "R8 grade", 1);
        // saturation: R10
        run_meas(1, 20000, 4, 64'h0_FFFF_FFFF, 0, 32'hFFFF_FFFF, F_PASS, "R10", "R10 grade", 0);

        while (act_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule